// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block stores the on/off state of a 16-row by 8-column crosspoint switch matrix. Each of the 128 storage bits drives the enable of one switch. A write puts a 4-bit row code and a 3-bit column code on the address inputs, asserts chip select and strobe, and presents the desired state on the data input. The cell that the address picks follows the data input for as long as the write is enabled. When the strobe drops, the cell keeps the last value it took. All other cells are left alone. Any set of cells can be on at the same time, so one row may feed several columns and one column may gather several rows.

The column code selects its column directly. The row code goes through a fixed scramble first: codes 0–5 reach rows 0–5, codes 6 and 7 reach rows 12 and 13, codes 8–13 reach rows 6–11, and codes 14 and 15 reach rows 14 and 15. The cells are registers on a system clock. While a write is enabled, a cell reloads from the data input on every rising edge, which models a transparent latch with a clock. An active-high master clear empties every cell at once, without waiting for the clock. Its release passes through a two-stage synchronizer before writes are accepted again.

Top module: `xpt_matrix`

## Requirements
- R1: While `clear` is high, `xpt_on` is all zero, from the moment `clear` rises and without a clock edge. This holds whatever the values of `cs` and `strobe`.
- R2: After `clear` falls, a write presented at the first two rising clock edges is ignored. A write presented at the third and later edges takes effect.
- R3: Bit `row*8 + col` of `xpt_on` is the switch between physical row `row` and column `col`. A stored 1 means on and a stored 0 means off. The column code equals `col`.
- R4: Row codes 0–5 address rows 0–5, codes 6–7 address rows 12–13, codes 8–13 address rows 6–11, and codes 14–15 address rows 14–15.
- R5: A cell is loaded at a rising edge only if `cs` and `strobe` are both high at that edge. If either is low, `xpt_on` does not change.
- R6: While a write stays enabled, the addressed cell takes `data_in` at every rising edge. The value it holds after `strobe` falls is the value sampled at the last enabled edge.
- R7: A write changes at most the one addressed bit. All other bits of `xpt_on` keep their values.
- R8: Any number of cells may be on at once, including several in one row and several in one column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; cells load on the rising edge |
| clear | input | 1 | Master clear, active high, asynchronous assertion |
| cs | input | 1 | Chip select, active high |
| strobe | input | 1 | Write strobe, active high |
| data_in | input | 1 | State to store in the addressed cell (1 = on) |
| row_code | input | 4 | Row address code, scrambled to a physical row |
| col_code | input | 3 | Column address code, equal to the column number |
| xpt_on | output | 128 | Switch enables, bit row*8+col |

## Verification
The assertions assume that `cs`, `strobe`, `data_in` and both address codes are stable around each rising clock edge. This lets the register that holds the last write target line up with the cell that changed one cycle later. They also assume that `clear` is asserted from time zero, so that no comparison with a past value reaches back to before the first clear. The stimulus meets both assumptions. It holds `clear` high from the start and changes every control and address input only on the falling clock edge. Outputs are sampled on the falling edge, and the one check made directly after a mid-cycle clear also falls well clear of any rising edge.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  // Row scramble for the 4-bit row code: code -> physical row
  function automatic logic [3:0] scramble_row(input logic [3:0] code);
    logic [3:0] phys;
    if (code < 4'd6)       phys = code;
    else if (code < 4'd8)  phys = code + 4'd6;
    else if (code < 4'd14) phys = code - 4'd2;
    else                   phys = code;
    return phys;
  endfunction
endpackage

// File: rtl/xpt_rst_sync.sv
module xpt_rst_sync (
  input  logic clk,
  input  logic clear,
  output logic ready
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or posedge clear) begin
    if (clear) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign ready = stage2_q;
endmodule

// File: rtl/xpt_onehot.sv
module xpt_onehot #(
  parameter int AW = 3,
  localparam int N = 1 << AW
) (
  input  logic [AW-1:0] code,
  output logic [N-1:0]  sel
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign sel[i] = (code == AW'(i));
  end
endmodule

// File: rtl/xpt_row_map.sv
module xpt_row_map #(
  parameter int ROW_AW   = 4,
  parameter bit SCRAMBLE = 1'b1,
  localparam int NROW = 1 << ROW_AW
) (
  input  logic [ROW_AW-1:0] code,
  output logic [NROW-1:0]   row_sel
);
  logic [ROW_AW-1:0] phys;

  if (SCRAMBLE && ROW_AW == 4) begin : g_scramble
    assign phys = xpt_pkg::scramble_row(code);
  end else begin : g_linear
    assign phys = code;
  end

  xpt_onehot #(.AW(ROW_AW)) u_dec (
    .code (phys),
    .sel  (row_sel)
  );
endmodule

// File: rtl/xpt_cell_array.sv
module xpt_cell_array #(
  parameter int NROW = 16,
  parameter int NCOL = 8,
  localparam int NCELL = NROW * NCOL
) (
  input  logic             clk,
  input  logic             clear,
  input  logic [NROW-1:0]  row_sel,
  input  logic [NCOL-1:0]  col_sel,
  input  logic             wr_en,
  input  logic             data_in,
  output logic [NCELL-1:0] cells
);
  for (genvar r = 0; r < NROW; r++) begin : g_row
    for (genvar c = 0; c < NCOL; c++) begin : g_col
      logic load;
      logic cell_d;
      logic cell_q;

      always_comb begin
        load   = wr_en & row_sel[r] & col_sel[c];
        cell_d = cell_q;
        if (load) cell_d = data_in;
      end

      always_ff @(posedge clk or posedge clear) begin
        if (clear) cell_q <= 1'b0;
        else if (load) cell_q <= cell_d;
      end

      assign cells[r*NCOL + c] = cell_q;
    end
  end
endmodule

// File: rtl/xpt_matrix.sv
module xpt_matrix #(
  parameter int ROW_AW   = 4,
  parameter int COL_AW   = 3,
  parameter bit SCRAMBLE = 1'b1,
  localparam int NROW  = 1 << ROW_AW,
  localparam int NCOL  = 1 << COL_AW,
  localparam int NCELL = NROW * NCOL
) (
  input  logic              clk,
  input  logic              clear,
  input  logic              cs,
  input  logic              strobe,
  input  logic              data_in,
  input  logic [ROW_AW-1:0] row_code,
  input  logic [COL_AW-1:0] col_code,
  output logic [NCELL-1:0]  xpt_on
);
  logic            wr_ready;
  logic            wr_en;
  logic [NROW-1:0] row_sel;
  logic [NCOL-1:0] col_sel;

  xpt_rst_sync u_sync (
    .clk   (clk),
    .clear (clear),
    .ready (wr_ready)
  );

  xpt_row_map #(.ROW_AW(ROW_AW), .SCRAMBLE(SCRAMBLE)) u_row (
    .code    (row_code),
    .row_sel (row_sel)
  );

  xpt_onehot #(.AW(COL_AW)) u_col (
    .code (col_code),
    .sel  (col_sel)
  );

  assign wr_en = cs & strobe & wr_ready;

  xpt_cell_array #(.NROW(NROW), .NCOL(NCOL)) u_cells (
    .clk     (clk),
    .clear   (clear),
    .row_sel (row_sel),
    .col_sel (col_sel),
    .wr_en   (wr_en),
    .data_in (data_in),
    .cells   (xpt_on)
  );
endmodule

// File: rtl/xpt_matrix_chk.sv
module xpt_matrix_chk #(
  parameter int ROW_AW   = 4,
  parameter int COL_AW   = 3,
  parameter bit SCRAMBLE = 1'b1,
  localparam int NROW  = 1 << ROW_AW,
  localparam int NCOL  = 1 << COL_AW,
  localparam int NCELL = NROW * NCOL,
  localparam int IW    = ROW_AW + COL_AW
) (
  input logic              clk,
  input logic              clear,
  input logic              cs,
  input logic              strobe,
  input logic              data_in,
  input logic [ROW_AW-1:0] row_code,
  input logic [COL_AW-1:0] col_code,
  input logic              wr_ready,
  input logic [NCELL-1:0]  xpt_on
);
  logic [ROW_AW-1:0] phys_row;
  logic [IW-1:0]     tgt;
  logic [IW-1:0]     tgt_q;
  logic              data_q;

  always_comb begin
    phys_row = row_code;
    if (SCRAMBLE && ROW_AW == 4) begin
      case (row_code)
        ROW_AW'(6):  phys_row = ROW_AW'(12);
        ROW_AW'(7):  phys_row = ROW_AW'(13);
        ROW_AW'(8):  phys_row = ROW_AW'(6);
        ROW_AW'(9):  phys_row = ROW_AW'(7);
        ROW_AW'(10): phys_row = ROW_AW'(8);
        ROW_AW'(11): phys_row = ROW_AW'(9);
        ROW_AW'(12): phys_row = ROW_AW'(10);
        ROW_AW'(13): phys_row = ROW_AW'(11);
        default:     phys_row = row_code;
      endcase
    end
    tgt = {phys_row, col_code};
  end

  always_ff @(posedge clk) begin
    tgt_q  <= tgt;
    data_q <= data_in;
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk)
    clear |-> (xpt_on == '0));  // R1

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (clear)
    !wr_ready |=> $stable(xpt_on));  // R2

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (clear)
    (cs && strobe && wr_ready) |=> (xpt_on[tgt_q] == data_q));  // R6

  AST_GATED_WRITE: assert property (@(posedge clk) disable iff (clear)
    !(cs && strobe) |=> $stable(xpt_on));  // R5

  AST_ONE_CELL: assert property (@(posedge clk) disable iff (clear)
    $countones(xpt_on ^ $past(xpt_on)) <= 1);  // R7
endmodule

bind xpt_matrix xpt_matrix_chk #(
  .ROW_AW(ROW_AW), .COL_AW(COL_AW), .SCRAMBLE(SCRAMBLE)
) u_chk (
  .clk      (clk),
  .clear    (clear),
  .cs       (cs),
  .strobe   (strobe),
  .data_in  (data_in),
  .row_code (row_code),
  .col_code (col_code),
  .wr_ready (wr_ready),
  .xpt_on   (xpt_on)
);

// File: tb/test_xpt_matrix.sv
module test_xpt_matrix;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         clear;
  logic         cs;
  logic         strobe;
  logic         data_in;
  logic [3:0]   row_code;
  logic [2:0]   col_code;
  logic [127:0] xpt_on;
  logic [127:0] exp_vec;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xpt_matrix i_xpt_matrix (
    .clk      (clk),
    .clear    (clear),
    .cs       (cs),
    .strobe   (strobe),
    .data_in  (data_in),
    .row_code (row_code),
    .col_code (col_code),
    .xpt_on   (xpt_on)
  );

  function automatic int phys_of(input int code);
    if (code == 6) return 12;
    if (code == 7) return 13;
    if (code >= 8 && code <= 13) return code - 2;
    return code;
  endfunction

  function automatic int bit_of(input int code, input int col);
    return phys_of(code) * 8 + col;
  endfunction

  task automatic check(input string req, input logic [127:0] expv);
    n_checks++;
    if (xpt_on !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, xpt_on, expv);
    end
  endtask

  task automatic idle();
    cs = 1'b0; strobe = 1'b0; data_in = 1'b0;
  endtask

  // One enabled edge, then strobe and cs drop; result checked at the next falling edge
  task automatic write_cell(input int code, input int col, input logic d);
    @(negedge clk);
    row_code = 4'(code); col_code = 3'(col);
    cs = 1'b1; strobe = 1'b1; data_in = d;
    @(negedge clk);
    idle();
    exp_vec[bit_of(code, col)] = d;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    exp_vec = '0;
    @(negedge clk);
    clear = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    check("R1 reset state", '0);
    do_clear();
    check("R1 after clear release", '0);
  endtask

  task automatic t_every_address();
    for (int r = 0; r < 16; r++) begin
      for (int c = 0; c < 8; c++) begin
        logic [127:0] one;
        one = '0;
        one[bit_of(r, c)] = 1'b1;
        write_cell(r, c, 1'b1);
        check($sformatf("R3 R4 set code %0d col %0d", r, c), one);
        write_cell(r, c, 1'b0);
        check($sformatf("R3 off code %0d col %0d", r, c), '0);
      end
    end
  endtask

  task automatic t_many_on();
    write_cell(3, 0, 1'b1);
    write_cell(3, 2, 1'b1);
    write_cell(3, 7, 1'b1);
    write_cell(0, 4, 1'b1);
    write_cell(11, 4, 1'b1);
    write_cell(15, 4, 1'b1);
    check("R8 several per row and column", exp_vec);
    write_cell(3, 2, 1'b0);
    check("R7 partial update keeps others", exp_vec);
    write_cell(6, 1, 1'b1);
    check("R7 R4 code 6 adds row 12 only", exp_vec);
  endtask

  task automatic t_gating();
    @(negedge clk);
    row_code = 4'd9; col_code = 3'd6; data_in = 1'b1; cs = 1'b1; strobe = 1'b0;
    @(negedge clk);
    check("R5 strobe low ignored", exp_vec);
    cs = 1'b0; strobe = 1'b1;
    @(negedge clk);
    check("R5 cs low ignored", exp_vec);
    row_code = 4'd3; col_code = 3'd0; data_in = 1'b0;
    @(negedge clk);
    check("R5 cs low clear of set cell ignored", exp_vec);
    idle();
  endtask

  task automatic t_transparent();
    int b;
    b = bit_of(7, 5);
    @(negedge clk);
    row_code = 4'd7; col_code = 3'd5; cs = 1'b1; strobe = 1'b1; data_in = 1'b1;
    @(negedge clk);
    exp_vec[b] = 1'b1;
    check("R6 follows data high", exp_vec);
    data_in = 1'b0;
    @(negedge clk);
    exp_vec[b] = 1'b0;
    check("R6 follows data low", exp_vec);
    data_in = 1'b1;
    @(negedge clk);
    exp_vec[b] = 1'b1;
    check("R6 follows data high again", exp_vec);
    strobe = 1'b0; data_in = 1'b0;
    @(negedge clk);
    check("R6 value held after strobe falls", exp_vec);
    idle();
  endtask

  task automatic t_clear_priority();
    int b;
    b = bit_of(13, 3);
    @(negedge clk);
    row_code = 4'd13; col_code = 3'd3; cs = 1'b1; strobe = 1'b1; data_in = 1'b1;
    #(CLK_PERIOD/4);
    clear = 1'b1;
    #1;
    check("R1 clear acts without clock edge", '0);
    @(negedge clk);
    check("R1 clear wins over enabled write", '0);
    clear = 1'b0;
    @(negedge clk);
    check("R2 first edge after release ignored", '0);
    @(negedge clk);
    check("R2 second edge after release ignored", '0);
    @(negedge clk);
    exp_vec = '0;
    exp_vec[b] = 1'b1;
    check("R2 third edge after release writes", exp_vec);
    idle();
  endtask

  initial begin
    clear = 1'b1;
    row_code = '0; col_code = '0;
    idle();
    exp_vec = '0;
    repeat (2) @(negedge clk);
    t_reset_state();
    t_every_address();
    t_many_on();
    t_gating();
    t_transparent();
    t_clear_priority();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule